// File: doc/BRIEF.md
# Validated VID Reference Controller

This block turns a parallel voltage-identification code from a processor into the digital reference code of a voltage regulator. The code is read only on a slow sample strobe. A new value is taken as the target only after it has been read unchanged on several consecutive strobes, so glitches and skewed bit changes on the VID lines are rejected. Mapping VID codes to voltage happens outside the block, so the code it handles is an 8-bit linear reference value.

A mode input selects how the reference follows an accepted target. In jump mode the reference register takes the new value at once. In slew mode the reference moves one LSB (6.25 mV) per stepping tick toward the target until the two match. The stepping tick is the sample strobe divided by a parameter. A target that arrives during a slew redirects the walk from wherever the reference stands. A busy output shows when the reference has not yet reached the target.

Top module: `vid_ref_ctrl`

## Requirements
- R1: While `rstN` is low, `refCode` equals `bootCode` and `busy` is 0. After release both reference and target hold that boot value.
- R2: `vidCode` is read only on cycles where `sampleTick` is 1. A value present only on cycles without a tick has no effect on `refCode`.
- R3: A code becomes the new target only after STABLE_N (default 3) consecutive ticks read the same value, which also differs from the present target. A shorter run, or a run broken by a different value, changes nothing.
- R4: In jump mode (`slewMode` = 0), `refCode` equals the accepted code from the clock edge of the accepting tick. If the mode changes to jump while the reference differs from the target, `refCode` takes the target on the next edge.
- R5: In jump mode a target of any distance from the present reference is accepted and loaded in full. Step size is not limited.
- R6: In slew mode (`slewMode` = 1), `refCode` changes by exactly one per step, up when below the target and down when above it. It stops once it equals the target.
- R7: A slew step happens only on the STEP_DIV-th tick (default 9) of a free-running count of sample ticks. Steps during a long slew are therefore exactly STEP_DIV sample ticks apart.
- R8: A target accepted during a slew redirects the walk from the present reference, with no restart, and the reference ends at the newest target.
- R9: `busy` is 1 exactly when `refCode` differs from the latest accepted target.
- R10: A tick that reads a value equal to the present target clears the stability count, so runs on either side of it are not combined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One-cycle strobe marking a VID sample, about 3 MHz |
| slewMode | input | 1 | 0 = jump to the accepted code, 1 = walk one LSB per step tick |
| vidCode | input | 8 | Linear code requested by the processor |
| bootCode | input | 8 | Reference and target value loaded by reset |
| refCode | output | 8 | Present reference code for the DAC |
| busy | output | 1 | Reference has not yet reached the accepted target |

## Verification
Directed patterns cover each filter outcome: a run one tick too short, runs broken by a different value or by the current target, a glitch placed between ticks, and a full run. Together they separate a correct count of consecutive samples from counting all samples or sampling every cycle. Jump mode is tried with one-step and very large changes. Slew mode is tried with a multi-step rise, with the spacing between step edges measured in cycles, and with a reversal in the middle of a walk, which tells a retarget from the current reference apart from a restart. Seeded random sequences then mix modes, run lengths and code distances against a bench model built from the requirements.

// File: rtl/vidref_pkg.sv
package vidref_pkg;
  // Strobes from the control section to the datapath, valid for one cycle
  typedef struct packed {
    logic latchTarget;  // accept the present VID code as target
    logic loadJump;     // load reference directly (code or target)
    logic stepUp;       // reference + 1
    logic stepDown;     // reference - 1
  } ctrlStrb_t;
endpackage

// File: rtl/vidref_ctrl.sv
module vidref_ctrl
  import vidref_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int STABLE_N = 3,
  parameter int STEP_DIV = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              slewMode,
  input  logic [CODE_W-1:0] vidCode,
  input  logic [CODE_W-1:0] targetCode,
  input  logic              refBelow,
  input  logic              refAbove,
  output ctrlStrb_t         strb
);
  localparam int CNT_W = $clog2(STABLE_N + 1);
  localparam int DIV_W = $clog2(STEP_DIV + 1);

  // ---------------- stability filter ----------------
  logic [CODE_W-1:0] candQ;
  logic [CNT_W-1:0]  cntQ, cntNext;
  logic              accept;

  always_comb begin
    cntNext = cntQ;
    accept  = 1'b0;
    if (sampleTick) begin
      if (vidCode == targetCode)
        cntNext = '0;
      else if (cntQ != '0 && vidCode == candQ)
        cntNext = cntQ + 1'b1;
      else
        cntNext = CNT_W'(1);
      if (cntNext == CNT_W'(STABLE_N)) begin
        accept  = 1'b1;
        cntNext = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candQ <= '0;
      cntQ  <= '0;
    end else if (sampleTick) begin
      candQ <= vidCode;
      cntQ  <= cntNext;
    end
  end

  // ---------------- step tick divider ----------------
  logic stepTick;
  generate
    if (STEP_DIV <= 1) begin : g_noDiv
      assign stepTick = sampleTick;
    end else begin : g_div
      logic [DIV_W-1:0] divQ;
      logic             divWrap;
      assign divWrap  = (divQ == DIV_W'(STEP_DIV - 1));
      assign stepTick = sampleTick && divWrap;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           divQ <= '0;
        else if (sampleTick) divQ <= divWrap ? '0 : divQ + 1'b1;
      end
    end
  endgenerate

  // ---------------- strobe generation ----------------
  always_comb begin
    strb.latchTarget = accept;
    strb.loadJump    = !slewMode && (accept || refBelow || refAbove);
    strb.stepUp      = slewMode && stepTick && refBelow;
    strb.stepDown    = slewMode && stepTick && refAbove;
  end

  // R2
  accept_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchTarget |-> sampleTick);

  // R6
  step_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stepUp, strb.stepDown, strb.loadJump}));

  // R7
  step_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepUp || strb.stepDown) |-> sampleTick);
endmodule

// File: rtl/vidref_dp.sv
module vidref_dp
  import vidref_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] bootCode,
  input  logic [CODE_W-1:0] vidCode,
  input  ctrlStrb_t         strb,
  output logic [CODE_W-1:0] refCode,
  output logic [CODE_W-1:0] targetCode,
  output logic              refBelow,
  output logic              refAbove,
  output logic              busy
);
  logic [CODE_W-1:0] refQ, targetQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refQ    <= bootCode;
      targetQ <= bootCode;
    end else begin
      if (strb.latchTarget) targetQ <= vidCode;
      if (strb.loadJump)
        refQ <= strb.latchTarget ? vidCode : targetQ;
      else if (strb.stepUp)
        refQ <= refQ + 1'b1;
      else if (strb.stepDown)
        refQ <= refQ - 1'b1;
    end
  end

  assign refCode    = refQ;
  assign targetCode = targetQ;
  assign refBelow   = refQ < targetQ;
  assign refAbove   = refQ > targetQ;
  assign busy       = refQ != targetQ;

  // R3
  target_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchTarget |=> $stable(targetQ));

  // R4
  jump_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadJump |=> (refQ == targetQ));

  // R6
  ref_unit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadJump |=> (refQ == $past(refQ) || refQ == $past(refQ) + 1'b1
                        || refQ == $past(refQ) - 1'b1));

  // R7
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadJump || strb.stepUp || strb.stepDown) |=> $stable(refQ));
endmodule

// File: rtl/vid_ref_ctrl.sv
module vid_ref_ctrl
  import vidref_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int STABLE_N = 3,
  parameter int STEP_DIV = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              slewMode,
  input  logic [CODE_W-1:0] vidCode,
  input  logic [CODE_W-1:0] bootCode,
  output logic [CODE_W-1:0] refCode,
  output logic              busy
);
  ctrlStrb_t         strb;
  logic [CODE_W-1:0] targetCode;
  logic              refBelow, refAbove;

  vidref_ctrl #(.CODE_W(CODE_W), .STABLE_N(STABLE_N), .STEP_DIV(STEP_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .slewMode(slewMode),
    .vidCode(vidCode), .targetCode(targetCode), .refBelow(refBelow),
    .refAbove(refAbove), .strb(strb)
  );

  vidref_dp #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .bootCode(bootCode), .vidCode(vidCode), .strb(strb),
    .refCode(refCode), .targetCode(targetCode), .refBelow(refBelow),
    .refAbove(refAbove), .busy(busy)
  );

  // R9
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> (!busy || $changed(targetCode)));
endmodule

// File: tb/vid_ref_ctrl_bench.sv
module vid_ref_ctrl_bench;
  localparam int GAP      = 4;
  localparam int STABLE_N = 3;
  localparam int STEP_DIV = 9;
  localparam int STEP_CYC = GAP * STEP_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       slewMode = 1'b0;
  logic [7:0] vidCode = 8'h40;
  logic [7:0] bootCode = 8'h40;
  logic [7:0] refCode;
  logic       busy;

  int    checks = 0;
  int    fails = 0;
  int    phase = 0;
  bit    running = 1'b0;
  bit    finished = 1'b0;
  string curTag = "R1";

  always #4 clk = ~clk;

  vid_ref_ctrl #(.CODE_W(8), .STABLE_N(STABLE_N), .STEP_DIV(STEP_DIV)) u_vid_ref_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .slewMode(slewMode),
    .vidCode(vidCode), .bootCode(bootCode), .refCode(refCode), .busy(busy)
  );

  // ---------------- requirement model ----------------
  logic [7:0] mRef, mTgt, mCand;
  int         mCnt, mDiv;

  always @(posedge clk) begin
    int         nc;
    bit         acc, stepT;
    logic [7:0] oldT;
    if (!rstN) begin
      mRef = bootCode; mTgt = bootCode; mCand = 8'h00; mCnt = 0; mDiv = 0;
    end else begin
      acc = 1'b0; stepT = 1'b0;
      if (sampleTick) begin
        if (vidCode == mTgt) nc = 0;
        else if (mCnt != 0 && vidCode == mCand) nc = mCnt + 1;
        else nc = 1;
        if (nc == STABLE_N) begin acc = 1'b1; nc = 0; end
        mCnt = nc; mCand = vidCode;
        if (mDiv == STEP_DIV - 1) begin stepT = 1'b1; mDiv = 0; end
        else mDiv = mDiv + 1;
      end
      oldT = mTgt;
      if (acc) mTgt = vidCode;
      if (!slewMode) mRef = mTgt;
      else if (stepT) begin
        if (mRef < oldT) mRef = mRef + 8'd1;
        else if (mRef > oldT) mRef = mRef - 8'd1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (running) begin
      check({curTag, " ref"}, int'(refCode), int'(mRef));
      check("R9 busy", int'(busy), int'(mRef != mTgt));
    end
  end

  task automatic stepc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      phase = (phase + 1) % GAP;
      sampleTick = (phase == 0);
    end
  endtask

  task automatic align();
    do stepc(1); while (!sampleTick);
  endtask

  task automatic holdVid(logic [7:0] code, int ticks);
    align();
    vidCode = code;
    stepc(ticks * GAP);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lastT, nowT;
    logic [7:0] prev;
    void'($urandom(32'd20240611));
    running = 1'b1;
    // R1 reset state
    curTag = "R1";
    stepc(5);
    check("R1 reset ref", int'(refCode), 'h40);
    check("R1 reset busy", int'(busy), 0);
    rstN = 1'b1;
    stepc(3);
    check("R1 after release", int'(refCode), 'h40);

    // R3 short runs and broken runs
    curTag = "R3";
    holdVid(8'h41, 2);
    vidCode = 8'h42; stepc(2 * GAP);
    vidCode = 8'h41; stepc(2 * GAP);
    check("R3 short run ignored", int'(refCode), 'h40);
    // R10 current target breaks a run
    curTag = "R10";
    vidCode = 8'h40; stepc(GAP);
    vidCode = 8'h41; stepc(2 * GAP);
    check("R10 run split by target", int'(refCode), 'h40);
    vidCode = 8'h40; stepc(2 * GAP);

    // R2 glitch between ticks
    curTag = "R2";
    for (int g = 0; g < 3; g++) begin
      align(); stepc(1);
      vidCode = 8'h55; stepc(1);
      vidCode = 8'h40; stepc(GAP - 1);
    end
    check("R2 off-tick glitch ignored", int'(refCode), 'h40);

    // R4 jump after full run
    curTag = "R4";
    holdVid(8'h41, 3);
    check("R4 jump lands", int'(refCode), 'h41);
    check("R4 not busy", int'(busy), 0);
    // R5 large jump
    curTag = "R5";
    holdVid(8'hC0, 3);
    check("R5 large jump", int'(refCode), 'hC0);

    // R6/R7 slew with measured spacing
    curTag = "R6";
    slewMode = 1'b1;
    holdVid(8'hC5, 3);
    check("R9 busy during slew", int'(busy), 1);
    lastT = -1; nowT = 0; prev = refCode;
    for (int c = 0; c < 6 * STEP_CYC; c++) begin
      stepc(1); nowT++;
      if (refCode != prev) begin
        if (lastT >= 0) check("R7 step spacing", nowT - lastT, STEP_CYC);
        lastT = nowT; prev = refCode;
      end
    end
    check("R6 slew end", int'(refCode), 'hC5);
    check("R9 idle after slew", int'(busy), 0);

    // R8 retarget mid-slew
    curTag = "R8";
    holdVid(8'h10, 3);
    stepc(3 * STEP_CYC);
    holdVid(8'hD0, 3);
    stepc(20 * STEP_CYC);
    check("R8 retarget end", int'(refCode), 'hD0);

    // R4 mode switch while busy
    curTag = "R4";
    holdVid(8'h20, 3);
    stepc(2 * STEP_CYC);
    slewMode = 1'b0;
    stepc(1);
    check("R4 snap on mode switch", int'(refCode), 'h20);

    // random mix
    curTag = "R6 random";
    for (int it = 0; it < 60; it++) begin
      slewMode = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 0) vidCode = refCode + 8'($urandom_range(0, 4)) - 8'd2;
      else vidCode = 8'($urandom_range(0, 255));
      stepc($urandom_range(1, 5) * GAP + $urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) stepc($urandom_range(1, 400));
    end
    slewMode = 1'b0;
    stepc(4 * GAP);
    check("R4 final settle", int'(busy), 0);

    running = 1'b0;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule